// File: doc/BRIEF.md
# AC-link Codec Command Port

This block sits on the codec side of an AC-link serial interface, after the deserializer. Each input frame arrives in parallel as a 16-bit tag slot plus twelve 20-bit data slots. The block decodes the command address slot (slot 1) and the command data slot (slot 2). With them it writes to, or reads from, a bank of sixty-four 16-bit control registers. The registers are indexed by a 7-bit even index, so entry N sits at index 2N. A read answer is held on the status outputs for the serializer to place into the next input frame.

The block also steers a stereo playback pair to the DAC. A 2-bit field in one control register picks which slot pair of the frame carries the left and right samples. The chosen 20-bit samples leave on a valid/ready stream.

Frames enter on a valid/ready stream. A frame is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the one-entry DAC output register is empty, or is being drained in that same cycle (`dac_ready` high). The DAC stream holds `dac_valid` and its data unchanged until `dac_ready` is seen. The status outputs are plain registered pins. They are reloaded on every accepted frame.

Top module: `ac_cmd_port`

## Requirements
- R1: After reset, all 64 registers read as zero, `dac_valid` and `sts_valid` are low, `sts_addr` and `sts_data` are zero, `in_ready` is high, and the DAC pair is slots 3 and 4.
- R2: A frame whose tag has bit 15 (frame valid), bit 14 (slot 1 valid) and bit 13 (slot 2 valid) set, and whose slot 1 has bit 19 equal to 0 (write), stores slot 2 bits 19:4 into the register at the index in slot 1 bits 18:12.
- R3: A write to an odd index, a write in a frame with tag bit 15, 14 or 13 clear, and a write beyond the implemented entries change no register.
- R4: A frame with tag bits 15 and 14 set and slot 1 bit 19 equal to 1 (read) is answered from the edge that accepts it. The answer raises `sts_valid`, drives `sts_addr` to the index in bits 18:12 with all other bits zero, and drives `sts_data` to the register value in bits 19:4 with bits 3:0 zero.
- R5: A read leaves every register unchanged, even when slot 2 carries non-zero data and tag bit 13 is set.
- R6: A read of an odd index echoes that index and returns zero data.
- R7: Bits 1:0 of the register at index 0x76 select the DAC pair as left/right: 0 gives slots 3/4, 1 gives slots 7/8, 2 gives slots 6/9, and 3 gives slots 10/11. Slot n is valid when tag bit 15-n is set. A change takes effect from the frame after the writing frame.
- R8: An accepted frame with tag bit 15 and both selected slot-valid bits set puts exactly one sample pair on the DAC stream, carrying the full 20-bit slots. A frame lacking any of those bits puts none.
- R9: While `dac_valid` is high and `dac_ready` is low, `dac_valid`, `dac_left` and `dac_right` stay unchanged and `in_ready` is low.
- R10: An accepted frame that is not a read clears `sts_valid`, `sts_addr` and `sts_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Block accepts the frame this cycle |
| in_tag | input | 16 | Tag slot of the frame |
| in_slots | input | 240 | Slots 1..12; slot n in bits n*20-1 down to (n-1)*20 |
| dac_valid | output | 1 | DAC sample pair present |
| dac_ready | input | 1 | DAC sink takes the pair |
| dac_left | output | 20 | Left playback sample |
| dac_right | output | 20 | Right playback sample |
| sts_valid | output | 1 | Status slots carry a read answer |
| sts_addr | output | 20 | Status address slot (index in bits 18:12) |
| sts_data | output | 20 | Status data slot (value in bits 19:4) |

## Verification
The bench writes to an odd index next to the slot-map register. A design that drops bit 0 of the index would overwrite the even neighbour and also re-route the DAC. It issues reads whose data slot is not zero and has the slot 2 valid bit set. A decoder that ignores the read flag would corrupt the register that is read. It walks all four slot-pair mappings, and checks that the mapping changes only on frames after the writing frame. It also sends frames that lack one selected slot's valid bit, so a design that ignores the tag would emit extra samples. During a stalled sink it checks that samples are neither lost nor duplicated, and that input frames are held off.

// File: rtl/ac_cmd_pkg.sv
package ac_cmd_pkg;
  localparam int SLOT_W    = 20;
  localparam int TAG_W     = 16;
  localparam int IDX_W     = 7;
  localparam int REG_W     = 16;
  localparam int RW_BIT    = SLOT_W - 1;
  localparam int FRM_BIT   = TAG_W - 1;
  localparam int PAD_W     = SLOT_W - REG_W;

  typedef enum logic [1:0] {
    PAIR_3_4   = 2'd0,
    PAIR_7_8   = 2'd1,
    PAIR_6_9   = 2'd2,
    PAIR_10_11 = 2'd3
  } dac_pair_e;

  // tag bit that marks slot n as valid
  function automatic int tag_pos(input int n);
    return TAG_W - 1 - n;
  endfunction
endpackage

// File: rtl/ac_cmd_decode.sv
module ac_cmd_decode
  import ac_cmd_pkg::*;
#(
  parameter int REG_CNT = 64,
  parameter int ENT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [TAG_W-1:0]    tag,
  input  logic [SLOT_W-1:0]   addr_slot,
  input  logic [SLOT_W-1:0]   data_slot,
  output logic                we,
  output logic                rd,
  output logic                rd_zero,
  output logic [ENT_W-1:0]    ent,
  output logic [IDX_W-1:0]    idx,
  output logic [REG_W-1:0]    wdata
);
  logic frame_ok;
  logic impl;

  assign idx      = addr_slot[RW_BIT-1 -: IDX_W];
  assign ent      = idx[ENT_W:1];
  assign impl     = (int'(idx[IDX_W-1:1]) < REG_CNT);
  assign frame_ok = fire && tag[FRM_BIT] && tag[tag_pos(1)];
  assign rd       = frame_ok && addr_slot[RW_BIT];
  assign we       = frame_ok && !addr_slot[RW_BIT] && tag[tag_pos(2)]
                    && !idx[0] && impl;
  assign rd_zero  = idx[0] || !impl;
  assign wdata    = data_slot[SLOT_W-1 -: REG_W];

  // R3: an odd index never reaches the bank write strobe
  a_r3_odd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && addr_slot[RW_BIT-IDX_W]) |-> !we);
  // R5: a read flag in slot 1 never produces a write
  a_r5_read_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && addr_slot[RW_BIT]) |-> !we);
endmodule

// File: rtl/ac_reg_bank.sv
module ac_reg_bank
  import ac_cmd_pkg::*;
#(
  parameter int              REG_CNT = 64,
  parameter int              ENT_W   = 6,
  parameter logic [IDX_W-1:0] MAP_IDX = 7'h76
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ENT_W-1:0]  waddr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [ENT_W-1:0]  raddr,
  output logic [REG_W-1:0]  rdata,
  output dac_pair_e         pair
);
  localparam logic [ENT_W-1:0] MAP_ENT = MAP_IDX[ENT_W:1];

  logic [REG_CNT-1:0][REG_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign pair  = dac_pair_e'(mem[MAP_ENT][1:0]);

  // R3 / R5: contents move only on a write strobe
  a_r5_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
  // R2: a write lands at its entry
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ac_dac_steer.sv
module ac_dac_steer
  import ac_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fire,
  input  logic [TAG_W-1:0]              tag,
  input  logic [NUM_SLOTS*SLOT_W-1:0]   slots,
  input  dac_pair_e                     pair,
  output logic                          dac_valid,
  input  logic                          dac_ready,
  output logic [SLOT_W-1:0]             dac_left,
  output logic [SLOT_W-1:0]             dac_right
);
  logic [SLOT_W-1:0] slot_arr [1:NUM_SLOTS];
  logic [NUM_SLOTS:1] slot_ok;

  for (genvar n = 1; n <= NUM_SLOTS; n++) begin : g_slot
    assign slot_arr[n] = slots[n*SLOT_W-1 -: SLOT_W];
    assign slot_ok[n]  = tag[TAG_W-1-n];
  end

  logic [SLOT_W-1:0] l_smp, r_smp;
  logic              l_ok, r_ok, take;

  always_comb begin
    unique case (pair)
      PAIR_7_8:   begin l_smp = slot_arr[7];  r_smp = slot_arr[8];
                        l_ok  = slot_ok[7];   r_ok  = slot_ok[8];  end
      PAIR_6_9:   begin l_smp = slot_arr[6];  r_smp = slot_arr[9];
                        l_ok  = slot_ok[6];   r_ok  = slot_ok[9];  end
      PAIR_10_11: begin l_smp = slot_arr[10]; r_smp = slot_arr[11];
                        l_ok  = slot_ok[10];  r_ok  = slot_ok[11]; end
      default:    begin l_smp = slot_arr[3];  r_smp = slot_arr[4];
                        l_ok  = slot_ok[3];   r_ok  = slot_ok[4];  end
    endcase
  end

  assign take = fire && tag[FRM_BIT] && l_ok && r_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_valid <= 1'b0;
      dac_left  <= '0;
      dac_right <= '0;
    end else if (take) begin
      dac_valid <= 1'b1;
      dac_left  <= l_smp;
      dac_right <= r_smp;
    end else if (dac_ready) begin
      dac_valid <= 1'b0;
    end
  end

  // R9: a stalled pair is held intact
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && !dac_ready) |=>
      (dac_valid && $stable(dac_left) && $stable(dac_right)));
  // R8: no frame accepted and nothing drained means no change
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !dac_valid) |=> !dac_valid);
endmodule

// File: rtl/ac_cmd_port.sv
module ac_cmd_port
  import ac_cmd_pkg::*;
#(
  parameter int              NUM_SLOTS = 12,
  parameter int              REG_CNT   = 64,
  parameter logic [IDX_W-1:0] MAP_IDX   = 7'h76
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [15:0]                  in_tag,
  input  logic [NUM_SLOTS*20-1:0]      in_slots,
  output logic                         dac_valid,
  input  logic                         dac_ready,
  output logic [19:0]                  dac_left,
  output logic [19:0]                  dac_right,
  output logic                         sts_valid,
  output logic [19:0]                  sts_addr,
  output logic [19:0]                  sts_data
);
  localparam int ENT_W = $clog2(REG_CNT);

  logic              fire;
  logic              bank_we, cmd_rd, rd_zero;
  logic [ENT_W-1:0]  ent;
  logic [IDX_W-1:0]  idx;
  logic [REG_W-1:0]  wdata, rdata;
  dac_pair_e         pair;

  assign in_ready = !dac_valid || dac_ready;
  assign fire     = in_valid && in_ready;

  ac_cmd_decode #(.REG_CNT(REG_CNT), .ENT_W(ENT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .tag(in_tag),
    .addr_slot(in_slots[SLOT_W-1:0]),
    .data_slot(in_slots[2*SLOT_W-1:SLOT_W]),
    .we(bank_we), .rd(cmd_rd), .rd_zero(rd_zero),
    .ent(ent), .idx(idx), .wdata(wdata)
  );

  ac_reg_bank #(.REG_CNT(REG_CNT), .ENT_W(ENT_W), .MAP_IDX(MAP_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .waddr(ent), .wdata(wdata),
    .raddr(ent), .rdata(rdata), .pair(pair)
  );

  ac_dac_steer #(.NUM_SLOTS(NUM_SLOTS)) u_steer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .tag(in_tag), .slots(in_slots),
    .pair(pair), .dac_valid(dac_valid), .dac_ready(dac_ready),
    .dac_left(dac_left), .dac_right(dac_right)
  );

  // status answer for the next outgoing frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_valid <= 1'b0;
      sts_addr  <= '0;
      sts_data  <= '0;
    end else if (fire) begin
      sts_valid <= cmd_rd;
      sts_addr  <= cmd_rd ? {1'b0, idx, {(SLOT_W-1-IDX_W){1'b0}}} : '0;
      sts_data  <= (cmd_rd && !rd_zero) ? {rdata, {PAD_W{1'b0}}} : '0;
    end
  end

  // R4: an accepted read raises the status flag
  a_r4_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_rd) |=> sts_valid);
  // R10: an accepted non-read frame clears it
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cmd_rd) |=> (!sts_valid && sts_addr == '0 && sts_data == '0));
  // R9: a stalled sink holds input off
  a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && !dac_ready) |-> !in_ready);
  // R6: status data low nibble is always clear
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sts_data[PAD_W-1:0] == '0);
endmodule

// File: tb/ac_cmd_port_test.sv
`timescale 1ns/100ps
module ac_cmd_port_test;
  localparam int NS = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_tag = '0;
  logic [NS*20-1:0] in_slots = '0;
  logic          dac_valid;
  logic          dac_ready = 1'b1;
  logic [19:0]   dac_left, dac_right;
  logic          sts_valid;
  logic [19:0]   sts_addr, sts_data;

  always #2.5 clk = ~clk;

  ac_cmd_port uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_slots(in_slots), .dac_valid(dac_valid),
    .dac_ready(dac_ready), .dac_left(dac_left), .dac_right(dac_right),
    .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_data(sts_data)
  );

  int checks = 0;
  int errors = 0;
  logic [39:0] exp_q [$];
  logic [15:0] m [64];
  logic [1:0]  mmap = 2'd0;
  logic [NS*20-1:0] fr;
  bit   stall = 1'b0;
  int   cyc = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [39:0] act,
                     input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setslot(input int n, input logic [19:0] v);
    fr[(n-1)*20 +: 20] = v;
  endtask

  function automatic logic [15:0] tbit(input int n);
    return 16'h1 << (15 - n);
  endfunction

  function automatic logic [19:0] getslot(input int n);
    return fr[(n-1)*20 +: 20];
  endfunction

  // driver: applies a frame, updates the model, checks status
  task automatic send(input logic [15:0] tg, input string req);
    logic [19:0] a, d;
    logic [6:0]  ix;
    int l, r;
    bit exp_v;
    logic [19:0] exp_a, exp_d;
    in_tag = tg; in_slots = fr; in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #0.5 in_valid = 1'b0;
    a = getslot(1); d = getslot(2); ix = a[18:12];
    case (mmap)
      2'd1: begin l = 7;  r = 8;  end
      2'd2: begin l = 6;  r = 9;  end
      2'd3: begin l = 10; r = 11; end
      default: begin l = 3; r = 4; end
    endcase
    if (tg[15] && (tg & tbit(l)) != 0 && (tg & tbit(r)) != 0)
      exp_q.push_back({getslot(l), getslot(r)});
    if (tg[15] && tg[14] && a[19]) begin
      exp_v = 1'b1; exp_a = {1'b0, ix, 12'h000};
      exp_d = ix[0] ? 20'h0 : {m[ix[6:1]], 4'h0};
    end else begin
      exp_v = 1'b0; exp_a = '0; exp_d = '0;
    end
    if (tg[15] && tg[14] && tg[13] && !a[19] && !ix[0]) begin
      m[ix[6:1]] = d[19:4];
      if (ix == 7'h76) mmap = d[5:4];
    end
    @(negedge clk);
    #0.2;
    chk(sts_valid == exp_v && sts_addr == exp_a && sts_data == exp_d, req,
        {sts_valid, sts_addr[18:0], sts_data}, {exp_v, exp_a[18:0], exp_d});
  endtask

  task automatic wr(input logic [6:0] ix, input logic [15:0] v,
                    input logic [15:0] tg, input string req);
    fr = '0;
    setslot(1, {1'b0, ix, 12'h000});
    setslot(2, {v, 4'h0});
    send(tg, req);
  endtask

  task automatic rd(input logic [6:0] ix, input string req);
    fr = '0;
    setslot(1, {1'b1, ix, 12'h000});
    send(16'hC000, req);
  endtask

  task automatic play(input logic [15:0] tg, input logic [19:0] seed,
                      input string req);
    fr = '0;
    for (int n = 3; n <= NS; n++) setslot(n, seed + 20'(n * 20'h111));
    send(tg, req);
  endtask

  // monitor: scoreboard pop and stall checks
  logic        held = 1'b0;
  logic [39:0] held_v;
  always begin
    @(negedge clk);
    cyc++;
    dac_ready = stall ? (cyc % 3 == 2) : 1'b1;
    #0.5;
    if (rst_n && held)
      chk(dac_valid && {dac_left, dac_right} == held_v, "R9 hold",
          {dac_left, dac_right}, held_v);
    held = 1'b0;
    if (rst_n && dac_valid && !dac_ready) begin
      chk(!in_ready, "R9 in_ready", {39'h0, in_ready}, 40'h0);
      held = 1'b1; held_v = {dac_left, dac_right};
    end
    if (rst_n && dac_valid && dac_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 extra sample", {dac_left, dac_right}, 40'h0);
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        chk({dac_left, dac_right} == e, "R7 R8 sample",
            {dac_left, dac_right}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #0.7;
    chk(in_ready && !dac_valid && !sts_valid && sts_addr == 0 && sts_data == 0,
        "R1 reset outputs", {in_ready, dac_valid, sts_valid, sts_addr[18:0],
        sts_data[18:0]}, {1'b1, 39'h0});
    @(negedge clk);
    rd(7'h00, "R1 reset reg 0");
    rd(7'h7E, "R1 reset reg 7E");
    rd(7'h76, "R1 reset map reg");
    play(16'h9800, 20'h10000, "R1 default pair 3/4");

    wr(7'h02, 16'hBEEF, 16'hE000, "R10 write clears status");
    wr(7'h7E, 16'h1234, 16'hE000, "R2 write top");
    wr(7'h00, 16'hFFFF, 16'hE000, "R2 write low");
    rd(7'h02, "R2 R4 read 02");
    rd(7'h7E, "R2 R4 read 7E");
    rd(7'h00, "R4 read 00");

    wr(7'h03, 16'hAAAA, 16'hE000, "R3 odd write");
    rd(7'h02, "R3 odd write kept 02");
    wr(7'h77, 16'h0003, 16'hE000, "R3 odd next to map");
    rd(7'h76, "R3 map untouched");
    wr(7'h10, 16'h5555, 16'h6000, "R3 no frame valid");
    wr(7'h10, 16'h5555, 16'hA000, "R3 no slot1 valid");
    wr(7'h10, 16'h5555, 16'hC000, "R3 no slot2 valid");
    rd(7'h10, "R3 guarded write kept");

    fr = '0;
    setslot(1, {1'b1, 7'h7E, 12'h000});
    setslot(2, {16'hDEAD, 4'h0});
    send(16'hE000, "R5 read with data");
    rd(7'h7E, "R5 register unchanged");
    rd(7'h05, "R6 odd read zero");
    rd(7'h7F, "R6 odd top read");

    // R7: walk the mappings; the writing frame still uses the old one
    fr = '0;
    for (int n = 3; n <= NS; n++) setslot(n, 20'hA0000 + 20'(n));
    setslot(1, {1'b0, 7'h76, 12'h000});
    setslot(2, {16'h0001, 4'h0});
    send(16'hFFF8, "R7 map write frame");
    play(16'h8000 | tbit(7) | tbit(8), 20'h20000, "R7 pair 7/8");
    play(16'h8000 | tbit(3) | tbit(4), 20'h21000, "R8 old pair ignored");
    wr(7'h76, 16'h0002, 16'hE000, "R7 map 6/9");
    play(16'h8000 | tbit(6) | tbit(9), 20'h30000, "R7 pair 6/9");
    play(16'h8000 | tbit(6), 20'h31000, "R8 missing right");
    wr(7'h76, 16'h0003, 16'hE000, "R7 map 10/11");
    play(16'h8000 | tbit(10) | tbit(11), 20'h40000, "R7 pair 10/11");
    play(16'h0000 | tbit(10) | tbit(11), 20'h41000, "R8 frame invalid");
    play(16'h8000 | tbit(11), 20'h42000, "R8 missing left");
    wr(7'h76, 16'h0000, 16'hE000, "R7 map back 3/4");
    play(16'hFFF8, 20'h50000, "R8 all valid 3/4");

    stall = 1'b1;
    for (int k = 0; k < 8; k++)
      play(16'h9800, 20'h60000 + 20'(k * 20'h1001), "R9 stalled stream");
    stall = 1'b0;
    for (int w = 0; w < 50 && exp_q.size() != 0; w++) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all samples out", 40'(exp_q.size()), 40'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule